// File: doc/BRIEF.md
# Ping-Pong Dual SRAM Buffer Controller

This block sits between a processor that produces a stream of data words and a host that collects them later. It drives two external asynchronous SRAM banks in a ping-pong arrangement. At any moment one bank takes the processor's writes and the other is drained by the host's reads. The host decides when the roles exchange by issuing a swap command, typically once every several seconds of captured data.

A swap does not happen the instant it is requested. The block waits until neither bank has an SRAM access in flight. Then it exchanges the roles and returns both the write and the read address to zero. It latches how many words went into the bank that has just been filled and raises a ready flag, so the host knows that bank can now be read. Each SRAM access lasts two clock cycles. In the first cycle the address and chip select are set up. In the second the write or output enable is pulsed. A processor or host strobe is taken only while its side has no access in progress and no swap is waiting. Writes beyond the bank depth are dropped and recorded in a sticky overflow flag.

Top module: `pingpong_sram_ctrl`

## Requirements
- R1: After reset, bank A holds the write role (`wr_bank` = 0), `data_ready` and `overflow` are low, and every chip-select, write-enable and output-enable output is high (inactive).
- R2: A write strobe sampled at a clock edge puts the write bank, in the next cycle, at the current write address with `ce_n` low, `we_n` high and data driven. In the cycle after that, `we_n` goes low for exactly one cycle. The write address then advances by one.
- R3: A read strobe sampled at a clock edge puts the read bank, in the next cycle, at the current read address with `ce_n` low and `oe_n` high. In the following cycle `oe_n` goes low. In the cycle after that, `rd_valid` is high for one cycle and `rd_data` holds the word stored at that address.
- R4: Write enables reach only the bank in the write role, and output enables reach only the bank in the read role. Bank A is in the write role when `wr_bank` is 0 and bank B when it is 1.
- R5: When no access is in progress, a swap command sampled at an edge inverts `wr_bank` and sets `data_ready` two edges later. Both the write and the read address restart at zero.
- R6: While a write or read access is in progress, a pending swap is held back. It takes effect at the first edge at which both sides are idle.
- R7: A swap command that arrives while an earlier one is still pending is merged with it, so the roles change only once.
- R8: At each swap, `word_count` takes the number of words written into the bank that is leaving the write role. This number is never more than the bank depth.
- R9: A `count_rd` pulse clears `data_ready` at the next edge.
- R10: `data_ready` clears at the end of the read access that brings the number of words read in this period up to a non-zero `word_count`.
- R11: A write strobe taken while the write address equals the bank depth starts no SRAM access and leaves memory unchanged. It sets `overflow`, which stays high until the next swap clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Processor write strobe |
| wr_data | input | DATA_W | Processor write word |
| rd_req | input | 1 | Host read strobe |
| rd_data | output | DATA_W | Word returned by the last read |
| rd_valid | output | 1 | One-cycle pulse when rd_data is new |
| swap_cmd | input | 1 | Host request to exchange bank roles |
| count_rd | input | 1 | Host has read word_count; clears data_ready |
| data_ready | output | 1 | Filled bank is available to the host |
| word_count | output | ADDR_W+1 | Words written during the last finished period |
| overflow | output | 1 | Sticky: a write was dropped because the bank was full |
| wr_bank | output | 1 | 0: bank A writes, bank B reads; 1: the reverse |
| a_addr | output | ADDR_W | Bank A address |
| a_ce_n | output | 1 | Bank A chip select, active low |
| a_we_n | output | 1 | Bank A write enable, active low |
| a_oe_n | output | 1 | Bank A output enable, active low |
| a_dq_oe | output | 1 | Drive bank A data lines |
| a_dq_out | output | DATA_W | Bank A write data |
| a_dq_in | input | DATA_W | Bank A read data |
| b_addr | output | ADDR_W | Bank B address |
| b_ce_n | output | 1 | Bank B chip select, active low |
| b_we_n | output | 1 | Bank B write enable, active low |
| b_oe_n | output | 1 | Bank B output enable, active low |
| b_dq_oe | output | 1 | Drive bank B data lines |
| b_dq_out | output | DATA_W | Bank B write data |
| b_dq_in | input | DATA_W | Bank B read data |

## Verification
A strobe sampled at edge n shows up as chip select at n+1 and as the enable pulse at n+2. Read data and the advanced address appear at n+3. Each stimulus is applied on a falling edge, and each of these windows is sampled on a falling edge, where it is checked against the bank the bench expects. A swap on idle engines is checked two falling edges after the command. A swap issued during an access is checked both before and after the access drains, and again some cycles later to confirm that a merged command left only one exchange. The sweep fills a small bank with every count from zero to the depth, and then past it. Expected contents, counts and flag levels are derived from the period index.

// File: rtl/pp_pkg.sv
package pp_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2
    } phase_t;

    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_t;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } strobe_t;

    localparam strobe_t STB_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

    function automatic strobe_t strobe_of(phase_t ph, logic is_write);
        strobe_t s;
        s = STB_IDLE;
        case (ph)
            PH_SETUP: begin
                s.ce_n  = 1'b0;
                s.dq_oe = is_write;
            end
            PH_STROBE: begin
                s.ce_n  = 1'b0;
                s.we_n  = ~is_write;
                s.oe_n  = is_write;
                s.dq_oe = is_write;
            end
            default: s = STB_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pp_access_seq.sv
module pp_access_seq
    import pp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output phase_t phase,
    output logic   idle,
    output logic   done
);
    phase_t phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
        end else begin
            case (phase_q)
                PH_IDLE:   if (start) phase_q <= PH_SETUP;
                PH_SETUP:  phase_q <= PH_STROBE;
                default:   phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase = phase_q;
    assign idle  = (phase_q == PH_IDLE);
    assign done  = (phase_q == PH_STROBE);
endmodule

// File: rtl/pp_addr_ctr.sv
module pp_addr_ctr #(
    parameter int CW = 19
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (inc) begin
            q <= q + CW'(1);
        end
    end
endmodule

// File: rtl/pp_role_ctrl.sv
module pp_role_ctrl
    import pp_pkg::*;
#(
    parameter int CW = 19
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          swap_cmd,
    input  logic          wr_idle,
    input  logic          rd_idle,
    input  logic [CW-1:0] wr_addr,
    input  logic [CW-1:0] rd_addr,
    input  logic          rd_done,
    input  logic          count_rd,
    input  logic          wr_drop,
    output bank_t         wr_bank,
    output logic          swap_pend,
    output logic          swap_fire,
    output logic [CW-1:0] word_count,
    output logic          data_ready,
    output logic          overflow
);
    bank_t         bank_q;
    logic          pend_q;
    logic [CW-1:0] count_q;
    logic          ready_q;
    logic          ovf_q;
    logic          last_read;

    assign swap_fire = pend_q && wr_idle && rd_idle;
    assign last_read = rd_done && (count_q != '0) && (rd_addr + CW'(1) == count_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q  <= BANK_A;
            pend_q  <= 1'b0;
            count_q <= '0;
            ready_q <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            pend_q <= (pend_q && !swap_fire) || swap_cmd;
            if (swap_fire) begin
                bank_q  <= (bank_q == BANK_A) ? BANK_B : BANK_A;
                count_q <= wr_addr;
                ready_q <= 1'b1;
                ovf_q   <= 1'b0;
            end else begin
                if (count_rd || last_read) ready_q <= 1'b0;
                if (wr_drop) ovf_q <= 1'b1;
            end
        end
    end

    assign wr_bank    = bank_q;
    assign swap_pend  = pend_q;
    assign word_count = count_q;
    assign data_ready = ready_q;
    assign overflow   = ovf_q;
endmodule

// File: rtl/pingpong_sram_ctrl.sv
module pingpong_sram_ctrl
    import pp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 18,
    parameter int DEPTH  = 2 ** ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              swap_cmd,
    input  logic              count_rd,
    output logic              data_ready,
    output logic [ADDR_W:0]   word_count,
    output logic              overflow,
    output logic              wr_bank,
    output logic [ADDR_W-1:0] a_addr,
    output logic              a_ce_n,
    output logic              a_we_n,
    output logic              a_oe_n,
    output logic              a_dq_oe,
    output logic [DATA_W-1:0] a_dq_out,
    input  logic [DATA_W-1:0] a_dq_in,
    output logic [ADDR_W-1:0] b_addr,
    output logic              b_ce_n,
    output logic              b_we_n,
    output logic              b_oe_n,
    output logic              b_dq_oe,
    output logic [DATA_W-1:0] b_dq_out,
    input  logic [DATA_W-1:0] b_dq_in
);
    localparam int CW = ADDR_W + 1;
    localparam int NBANK = 2;
    localparam logic [CW-1:0] FULL_AT = CW'(DEPTH);

    phase_t            wr_ph, rd_ph;
    logic              wr_idle, rd_idle, wr_done, rd_done;
    logic              wr_start, rd_start, wr_drop, wr_full, rd_end;
    logic [CW-1:0]     wr_addr, rd_addr;
    logic              swap_pend, swap_fire;
    bank_t             role;
    logic [DATA_W-1:0] wr_data_q, rd_data_q, rd_dq_in;
    logic              rd_valid_q;
    strobe_t           wr_stb, rd_stb;
    strobe_t           bank_stb  [NBANK];
    logic [ADDR_W-1:0] bank_addr [NBANK];

    assign wr_full  = (wr_addr == FULL_AT);
    assign rd_end   = (rd_addr == FULL_AT);
    assign wr_start = wr_req && wr_idle && !swap_pend && !wr_full;
    assign wr_drop  = wr_req && wr_idle && !swap_pend && wr_full;
    assign rd_start = rd_req && rd_idle && !swap_pend && !rd_end;

    pp_access_seq u_wr_seq (
        .clk(clk), .rst(rst), .start(wr_start),
        .phase(wr_ph), .idle(wr_idle), .done(wr_done)
    );

    pp_access_seq u_rd_seq (
        .clk(clk), .rst(rst), .start(rd_start),
        .phase(rd_ph), .idle(rd_idle), .done(rd_done)
    );

    pp_addr_ctr #(.CW(CW)) u_wr_addr (
        .clk(clk), .rst(rst), .clr(swap_fire), .inc(wr_done), .q(wr_addr)
    );

    pp_addr_ctr #(.CW(CW)) u_rd_addr (
        .clk(clk), .rst(rst), .clr(swap_fire), .inc(rd_done), .q(rd_addr)
    );

    pp_role_ctrl #(.CW(CW)) u_role (
        .clk(clk), .rst(rst), .swap_cmd(swap_cmd),
        .wr_idle(wr_idle), .rd_idle(rd_idle),
        .wr_addr(wr_addr), .rd_addr(rd_addr), .rd_done(rd_done),
        .count_rd(count_rd), .wr_drop(wr_drop),
        .wr_bank(role), .swap_pend(swap_pend), .swap_fire(swap_fire),
        .word_count(word_count), .data_ready(data_ready), .overflow(overflow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_data_q  <= '0;
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            if (wr_start) wr_data_q <= wr_data;
            if (rd_done) rd_data_q <= rd_dq_in;
            rd_valid_q <= rd_done;
        end
    end

    assign wr_stb   = strobe_of(wr_ph, 1'b1);
    assign rd_stb   = strobe_of(rd_ph, 1'b0);
    assign rd_dq_in = (role == BANK_A) ? b_dq_in : a_dq_in;

    generate
        for (genvar g = 0; g < NBANK; g++) begin : g_bank
            logic is_wr;
            assign is_wr        = (role == bank_t'(g));
            assign bank_stb[g]  = is_wr ? wr_stb : rd_stb;
            assign bank_addr[g] = is_wr ? wr_addr[ADDR_W-1:0] : rd_addr[ADDR_W-1:0];
        end
    endgenerate

    assign a_addr   = bank_addr[0];
    assign a_ce_n   = bank_stb[0].ce_n;
    assign a_we_n   = bank_stb[0].we_n;
    assign a_oe_n   = bank_stb[0].oe_n;
    assign a_dq_oe  = bank_stb[0].dq_oe;
    assign a_dq_out = wr_data_q;

    assign b_addr   = bank_addr[1];
    assign b_ce_n   = bank_stb[1].ce_n;
    assign b_we_n   = bank_stb[1].we_n;
    assign b_oe_n   = bank_stb[1].oe_n;
    assign b_dq_oe  = bank_stb[1].dq_oe;
    assign b_dq_out = wr_data_q;

    assign rd_data  = rd_data_q;
    assign rd_valid = rd_valid_q;
    assign wr_bank  = role;
endmodule

// File: rtl/pp_checker.sv
module pp_checker #(
    parameter int ADDR_W = 18,
    parameter int DEPTH  = 2 ** ADDR_W
) (
    input logic            clk,
    input logic            rst,
    input logic            a_ce_n,
    input logic            a_we_n,
    input logic            a_oe_n,
    input logic            b_ce_n,
    input logic            b_we_n,
    input logic            b_oe_n,
    input logic            wr_bank,
    input logic            data_ready,
    input logic            overflow,
    input logic [ADDR_W:0] word_count
);
    AST_WE_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
        !(!a_we_n && !b_we_n)); // R4
    AST_WE_ROLE_A: assert property (@(posedge clk) disable iff (rst)
        !a_we_n |-> (wr_bank == 1'b0)); // R4
    AST_OE_ROLE_B: assert property (@(posedge clk) disable iff (rst)
        !b_oe_n |-> (wr_bank == 1'b0)); // R4
    AST_WE_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
        $fell(a_we_n) |-> ($past(!a_ce_n) && $past(a_we_n))); // R2
    AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !a_we_n |=> a_we_n); // R2
    AST_OE_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
        $fell(b_oe_n) |-> $past(!b_ce_n)); // R3
    AST_SWAP_RAISES_READY: assert property (@(posedge clk) disable iff (rst)
        (wr_bank != $past(wr_bank)) |-> (data_ready && !overflow)); // R5
    AST_SWAP_IDLE_BANKS: assert property (@(posedge clk) disable iff (rst)
        (wr_bank != $past(wr_bank)) |-> ($past(a_ce_n) && $past(b_ce_n))); // R6
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        word_count <= (ADDR_W+1)'(DEPTH)); // R8
endmodule

bind pingpong_sram_ctrl pp_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_pp_checker (
    .clk(clk), .rst(rst),
    .a_ce_n(a_ce_n), .a_we_n(a_we_n), .a_oe_n(a_oe_n),
    .b_ce_n(b_ce_n), .b_we_n(b_we_n), .b_oe_n(b_oe_n),
    .wr_bank(wr_bank), .data_ready(data_ready),
    .overflow(overflow), .word_count(word_count)
);

// File: tb/pingpong_sram_ctrl_bench.sv
module pingpong_sram_ctrl_bench;
    localparam int DW = 16;
    localparam int AW = 3;
    localparam int DP = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_req = 1'b0, rd_req = 1'b0, swap_cmd = 1'b0, count_rd = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid, data_ready, overflow, wr_bank;
    logic [AW:0]   word_count;
    logic [AW-1:0] a_addr, b_addr;
    logic          a_ce_n, a_we_n, a_oe_n, a_dq_oe, b_ce_n, b_we_n, b_oe_n, b_dq_oe;
    logic [DW-1:0] a_dq_out, b_dq_out, a_dq_in, b_dq_in;
    logic [DW-1:0] mem_a [2**AW];
    logic [DW-1:0] mem_b [2**AW];

    int  checks = 0;
    int  failures = 0;
    bit  exp_bank = 1'b0;

    always #10 clk = ~clk;

    pingpong_sram_ctrl #(.DATA_W(DW), .ADDR_W(AW), .DEPTH(DP)) u_pingpong_sram_ctrl (
        .clk(clk), .rst(rst), .wr_req(wr_req), .wr_data(wr_data),
        .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid),
        .swap_cmd(swap_cmd), .count_rd(count_rd), .data_ready(data_ready),
        .word_count(word_count), .overflow(overflow), .wr_bank(wr_bank),
        .a_addr(a_addr), .a_ce_n(a_ce_n), .a_we_n(a_we_n), .a_oe_n(a_oe_n),
        .a_dq_oe(a_dq_oe), .a_dq_out(a_dq_out), .a_dq_in(a_dq_in),
        .b_addr(b_addr), .b_ce_n(b_ce_n), .b_we_n(b_we_n), .b_oe_n(b_oe_n),
        .b_dq_oe(b_dq_oe), .b_dq_out(b_dq_out), .b_dq_in(b_dq_in)
    );

    initial begin
        for (int i = 0; i < 2**AW; i++) begin
            mem_a[i] = 16'hFFFF;
            mem_b[i] = 16'hFFFF;
        end
    end

    always @(posedge clk) begin
        if (!a_ce_n && !a_we_n && a_dq_oe) mem_a[a_addr] <= a_dq_out;
        if (!b_ce_n && !b_we_n && b_dq_oe) mem_b[b_addr] <= b_dq_out;
    end

    assign a_dq_in = (!a_ce_n && !a_oe_n) ? mem_a[a_addr] : 16'hDEAD;
    assign b_dq_in = (!b_ce_n && !b_oe_n) ? mem_b[b_addr] : 16'hDEAD;

    // view of the banks by expected role
    logic          wb_ce_n, wb_we_n, wb_oe_n, wb_dq_oe, rb_ce_n, rb_we_n, rb_oe_n;
    logic [AW-1:0] wb_addr, rb_addr;
    assign wb_ce_n  = exp_bank ? b_ce_n  : a_ce_n;
    assign wb_we_n  = exp_bank ? b_we_n  : a_we_n;
    assign wb_oe_n  = exp_bank ? b_oe_n  : a_oe_n;
    assign wb_dq_oe = exp_bank ? b_dq_oe : a_dq_oe;
    assign wb_addr  = exp_bank ? b_addr  : a_addr;
    assign rb_ce_n  = exp_bank ? a_ce_n  : b_ce_n;
    assign rb_we_n  = exp_bank ? a_we_n  : b_we_n;
    assign rb_oe_n  = exp_bank ? a_oe_n  : b_oe_n;
    assign rb_addr  = exp_bank ? a_addr  : b_addr;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] wmem(input bit bank, input int idx);
        return bank ? mem_b[idx] : mem_a[idx];
    endfunction

    task automatic do_write(input logic [DW-1:0] v, input int idx, input bit ok);
        wr_req = 1'b1; wr_data = v;
        @(negedge clk);
        wr_req = 1'b0;
        if (ok) begin
            chk(wb_ce_n == 0 && wb_we_n == 1 && wb_dq_oe == 1, "R2 setup", {wb_ce_n, wb_we_n, wb_dq_oe}, 3'b011);
            chk(wb_addr == AW'(idx), "R2 addr", wb_addr, idx);
        end else begin
            chk(wb_ce_n == 1 && overflow == 1, "R11 drop", {wb_ce_n, overflow}, 2'b11);
        end
        @(negedge clk);
        if (ok) chk(wb_we_n == 0 && rb_we_n == 1, "R2 R4 strobe", {wb_we_n, rb_we_n}, 2'b01);
        @(negedge clk);
    endtask

    task automatic do_read(input logic [DW-1:0] exp, input int idx);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        chk(rb_ce_n == 0 && rb_oe_n == 1 && rb_addr == AW'(idx), "R3 setup", {rb_ce_n, rb_oe_n, rb_addr}, idx | (1 << AW));
        @(negedge clk);
        chk(rb_oe_n == 0 && wb_oe_n == 1, "R3 R4 oe", {rb_oe_n, wb_oe_n}, 2'b01);
        @(negedge clk);
        chk(rd_valid == 1 && rd_data == exp, "R3 data", rd_data, exp);
    endtask

    task automatic do_swap(input int exp_cnt);
        swap_cmd = 1'b1;
        @(negedge clk);
        swap_cmd = 1'b0;
        chk(wr_bank == exp_bank, "R5 not early", wr_bank, exp_bank);
        @(negedge clk);
        exp_bank = ~exp_bank;
        chk(wr_bank == exp_bank && data_ready == 1, "R5 swap", {wr_bank, data_ready}, {exp_bank, 1'b1});
        chk(word_count == (AW+1)'(exp_cnt), "R8 count", word_count, exp_cnt);
        chk(overflow == 0, "R11 clear", overflow, 0);
    endtask

    initial begin
        #4ms;
        failures++;
        $display("FAIL watchdog act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(wr_bank == 0 && data_ready == 0 && overflow == 0, "R1 flags", {wr_bank, data_ready, overflow}, 0);
        chk({a_ce_n, a_we_n, a_oe_n, b_ce_n, b_we_n, b_oe_n} == 6'b111111, "R1 strobes",
            {a_ce_n, a_we_n, a_oe_n, b_ce_n, b_we_n, b_oe_n}, 6'h3f);

        // sweep every fill level 0..DP
        for (int k = 0; k <= DP; k++) begin
            bit fb;
            fb = exp_bank;
            for (int i = 0; i < k; i++) do_write(16'(16'h100 * (k + 1) + i), i, 1'b1);
            for (int i = 0; i < k; i++)
                chk(wmem(fb, i) == 16'(16'h100 * (k + 1) + i), "R4 memory", wmem(fb, i), 16'h100 * (k + 1) + i);
            do_swap(k);
            for (int i = 0; i < k; i++) begin
                if (i == k - 1) chk(data_ready == 1, "R10 held", data_ready, 1);
                do_read(16'(16'h100 * (k + 1) + i), i);
            end
            if (k > 0) begin
                chk(data_ready == 0, "R10 cleared", data_ready, 0);
            end else begin
                count_rd = 1'b1;
                @(negedge clk);
                count_rd = 1'b0;
                chk(data_ready == 0, "R9 count_rd", data_ready, 0);
            end
        end

        // overflow: DP+2 writes into a DP-deep bank
        begin
            bit fb;
            fb = exp_bank;
            for (int i = 0; i < DP + 2; i++) do_write(16'(16'h0A00 + i), i, i < DP);
            chk(overflow == 1, "R11 sticky", overflow, 1);
            chk(wmem(fb, DP) == 16'hFFFF, "R11 memory", wmem(fb, DP), 16'hFFFF);
            do_swap(DP);
            count_rd = 1'b1;
            @(negedge clk);
            count_rd = 1'b0;
            chk(data_ready == 0, "R9 count_rd", data_ready, 0);
        end

        // swap held off by an access, second command merged
        wr_req = 1'b1; wr_data = 16'h5A5A;
        @(negedge clk);
        wr_req = 1'b0; swap_cmd = 1'b1;
        @(negedge clk);
        @(negedge clk);
        swap_cmd = 1'b0;
        chk(wr_bank == exp_bank, "R6 held", wr_bank, exp_bank);
        @(negedge clk);
        exp_bank = ~exp_bank;
        chk(wr_bank == exp_bank && word_count == 1, "R6 fired", {wr_bank, word_count}, {exp_bank, 4'd1});
        repeat (4) @(negedge clk);
        chk(wr_bank == exp_bank, "R7 merged", wr_bank, exp_bank);
        do_read(16'h5A5A, 0);
        chk(data_ready == 0, "R10 single", data_ready, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule